// File: doc/BRIEF.md
# Five-Operand 5:2 Compressor Row

The block takes five N-bit operands that all have the same weight and reduces them to two vectors, a sum and a carry. Shifting the carry vector left by one place and adding it to the sum vector gives exactly the total of the five operands. It is the reduction stage that sits ahead of a final carry-propagate adder, for example inside a multiplier or a multi-operand accumulator. The block has no clock and no state.

The row is one 5:2 compressor cell per bit position. Each cell has seven inputs: five operand bits of weight j and two lateral carry-ins from the cell at j-1. It has four outputs: a sum bit of weight j, and three bits of weight j+1, which are two lateral carry-outs and one carry. Both lateral carry-outs depend only on operand bits, so carries never ripple along the row.

A parameter selects how each cell is built. The fast form uses an XOR/mux network whose worst path is four XOR levels plus one mux. The cascade form chains three full adders, and its worst path is six XOR levels. The two forms give identical outputs for every input. The two lateral carries that leave the top cell are merged by a half adder into two extra result bits, so no weight is lost.

Top module: `cmp52_row`

## Requirements
- R1: For any operands, sum_o + (carry_o << 1), computed in WIDTH+3 bits, equals a_i + b_i + c_i + d_i + e_i.
- R2: In every cell, the sum bit plus twice the number of set bits among its carry, first lateral carry-out and second lateral carry-out equals the number of set bits among its seven inputs.
- R3: A cell's first lateral carry-out is 1 exactly when at least two of its operand bits 0, 1 and 2 are set. Its two carry-ins have no effect on it.
- R4: A cell's second lateral carry-out does not change when only its two carry-ins change.
- R5: The carry-ins of the cell at bit 0 are zero, so sum_o[0] equals the XOR of bit 0 of the five operands.
- R6: sum_o[WIDTH+1] and carry_o[WIDTH+1] are always 0. With all operands all-ones, R1 still holds, and the total is 5*(2^WIDTH-1).
- R7: The fast cell form and the cascade cell form agree on all four outputs for all 128 input combinations of a cell, and rows built from either form give the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand 0, feeds cell input 0 |
| b_i | input | WIDTH | Operand 1, feeds cell input 1 |
| c_i | input | WIDTH | Operand 2, feeds cell input 2 |
| d_i | input | WIDTH | Operand 3, feeds cell input 3 |
| e_i | input | WIDTH | Operand 4, feeds cell input 4 |
| sum_o | output | WIDTH+2 | Sum vector, bit j has weight 2^j |
| carry_o | output | WIDTH+2 | Carry vector, bit j has weight 2^(j+1) |

## Verification
In the same evaluation, a cell must both absorb the two lateral carries from its neighbour and produce fresh lateral carries for the next cell. An error in either one shows up only through the final total. All-ones operands make every cell's carry-ins and carry-outs high at once, and random vectors mix the two. Each result is judged by comparing the reconstructed total with a sum computed in the bench and with a row built from the other cell form. At the cell level, all 128 combinations are swept. The lateral carry-outs are compared across the four carry-in values of each operand pattern, which shows they do not depend on the carry-ins.

// File: rtl/cmp52_pkg.sv
package cmp52_pkg;
  typedef enum logic {
    CELL_FAST    = 1'b0,
    CELL_CASCADE = 1'b1
  } cell_form_e;
endpackage

// File: rtl/cmp52_fa.sv
module cmp52_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
endmodule

// File: rtl/cmp52_cell_cascade.sv
module cmp52_cell_cascade (
  input  logic [4:0] x_i,
  input  logic [1:0] ci_i,
  output logic       sum_o,
  output logic       co1_o,
  output logic       co2_o,
  output logic       cy_o
);
  logic s1_w, t_w;

  cmp52_fa u_fa0 (.a_i(x_i[0]), .b_i(x_i[1]), .c_i(x_i[2]), .s_o(s1_w),  .co_o(co1_o));
  cmp52_fa u_fa1 (.a_i(s1_w),   .b_i(x_i[3]), .c_i(x_i[4]), .s_o(t_w),   .co_o(co2_o));
  cmp52_fa u_fa2 (.a_i(t_w),    .b_i(ci_i[0]), .c_i(ci_i[1]), .s_o(sum_o), .co_o(cy_o));

  always_comb begin
    AST_CASCADE_WEIGHT: assert (int'(sum_o) + 2 * (int'(co1_o) + int'(co2_o) + int'(cy_o))
                                == $countones(x_i) + $countones(ci_i)); // R2
  end
endmodule

// File: rtl/cmp52_cell_fast.sv
module cmp52_cell_fast (
  input  logic [4:0] x_i,
  input  logic [1:0] ci_i,
  output logic       sum_o,
  output logic       co1_o,
  output logic       co2_o,
  output logic       cy_o
);
  logic p01_w, s1_w, p34_w, t_w, q_w, pc_w;

  // level 1: independent pairs
  assign p01_w = x_i[0] ^ x_i[1];
  assign p34_w = x_i[3] ^ x_i[4];
  assign pc_w  = ci_i[0] ^ ci_i[1];
  // level 2
  assign s1_w  = p01_w ^ x_i[2];
  assign co1_o = p01_w ? x_i[2] : x_i[0];
  // level 3
  assign t_w   = s1_w ^ p34_w;
  assign q_w   = s1_w ^ x_i[3];
  assign co2_o = q_w ? x_i[4] : s1_w;
  // level 4 + mux
  assign sum_o = t_w ^ pc_w;
  assign cy_o  = pc_w ? t_w : ci_i[0];

  always_comb begin
    AST_FAST_WEIGHT: assert (int'(sum_o) + 2 * (int'(co1_o) + int'(co2_o) + int'(cy_o))
                             == $countones(x_i) + $countones(ci_i)); // R2
    AST_CO1_PRIMARY: assert (co1_o == ($countones(x_i[2:0]) >= 2)); // R3
  end
endmodule

// File: rtl/cmp52_row.sv
module cmp52_row #(
  parameter int                    WIDTH     = 16,
  parameter cmp52_pkg::cell_form_e CELL_FORM = cmp52_pkg::CELL_FAST
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] e_i,
  output logic [WIDTH+1:0] sum_o,
  output logic [WIDTH+1:0] carry_o
);
  localparam int TW = WIDTH + 3;

  logic [WIDTH-1:0] s_w, co1_w, co2_w, cy_w;

  for (genvar j = 0; j < WIDTH; j++) begin : g_col
    logic [4:0] x_w;
    logic [1:0] ci_w;
    assign x_w = {e_i[j], d_i[j], c_i[j], b_i[j], a_i[j]};
    if (j == 0) begin : g_lsb
      assign ci_w = 2'b00;
    end else begin : g_mid
      assign ci_w = {co2_w[j-1], co1_w[j-1]};
    end
    if (CELL_FORM == cmp52_pkg::CELL_FAST) begin : g_fast
      cmp52_cell_fast u_cell (
        .x_i(x_w), .ci_i(ci_w), .sum_o(s_w[j]),
        .co1_o(co1_w[j]), .co2_o(co2_w[j]), .cy_o(cy_w[j])
      );
    end else begin : g_casc
      cmp52_cell_cascade u_cell (
        .x_i(x_w), .ci_i(ci_w), .sum_o(s_w[j]),
        .co1_o(co1_w[j]), .co2_o(co2_w[j]), .cy_o(cy_w[j])
      );
    end
  end

  // top lateral carries share weight WIDTH: fold with a half adder
  assign sum_o   = {1'b0, co1_w[WIDTH-1] ^ co2_w[WIDTH-1], s_w};
  assign carry_o = {1'b0, co1_w[WIDTH-1] & co2_w[WIDTH-1], cy_w};

  logic [TW-1:0] chk_total_w, chk_recon_w;
  always_comb begin
    chk_total_w = TW'(a_i) + TW'(b_i) + TW'(c_i) + TW'(d_i) + TW'(e_i);
    chk_recon_w = TW'(sum_o) + (TW'(carry_o) << 1);
    AST_ROW_TOTAL:  assert (chk_recon_w == chk_total_w); // R1
    AST_MSB_CLEAR:  assert (!sum_o[WIDTH+1] && !carry_o[WIDTH+1]); // R6
    AST_BIT0_PARITY: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ c_i[0] ^ d_i[0] ^ e_i[0])); // R5
  end
endmodule

// File: tb/cmp52_row_bench.sv
module cmp52_row_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int TW = W + 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [W-1:0] a, b, c, d, e;
  logic [W+1:0] sum_f, car_f, sum_r, car_r;

  cmp52_row #(.WIDTH(W)) u_cmp52_row (
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .e_i(e), .sum_o(sum_f), .carry_o(car_f)
  );
  cmp52_row #(.WIDTH(W), .CELL_FORM(cmp52_pkg::CELL_CASCADE)) u_cmp52_row_ref (
    .a_i(a), .b_i(b), .c_i(c), .d_i(d), .e_i(e), .sum_o(sum_r), .carry_o(car_r)
  );

  logic [4:0] cx;
  logic [1:0] cci;
  logic fs, f1, f2, fy, rs, r1, r2, ry;
  cmp52_cell_fast    u_cell_f (.x_i(cx), .ci_i(cci), .sum_o(fs), .co1_o(f1), .co2_o(f2), .cy_o(fy));
  cmp52_cell_cascade u_cell_r (.x_i(cx), .ci_i(cci), .sum_o(rs), .co1_o(r1), .co2_o(r2), .cy_o(ry));

  function automatic logic [TW-1:0] exp_total(logic [W-1:0] p, q, r, s, t);
    return TW'(p) + TW'(q) + TW'(r) + TW'(s) + TW'(t);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic row_vec(logic [W-1:0] p, q, r, s, t);
    logic [TW-1:0] recon, ex;
    @(posedge clk);
    a = p; b = q; c = r; d = s; e = t;
    @(negedge clk);
    recon = TW'(sum_f) + (TW'(car_f) << 1);
    ex    = exp_total(p, q, r, s, t);
    chk(recon == ex, "R1", 64'(recon), 64'(ex));
    chk(!sum_f[W+1] && !car_f[W+1], "R6", 64'({sum_f[W+1], car_f[W+1]}), 64'd0);
    chk(sum_f[0] == (p[0] ^ q[0] ^ r[0] ^ s[0] ^ t[0]), "R5", 64'(sum_f[0]),
        64'(p[0] ^ q[0] ^ r[0] ^ s[0] ^ t[0]));
    chk(sum_f == sum_r && car_f == car_r, "R7", 64'({sum_f, car_f}), 64'({sum_r, car_r}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ones;
    void'($urandom(32'd1234));
    ones = '1;
    a = '0; b = '0; c = '0; d = '0; e = '0; cx = '0; cci = '0;

    // zero operands
    @(negedge clk);
    chk(sum_f == '0 && car_f == '0, "R1", 64'({sum_f, car_f}), 64'd0);

    // cell sweep: x outer, carry-ins inner
    for (int xv = 0; xv < 32; xv++) begin
      logic base1, base2;
      base1 = 1'b0; base2 = 1'b0;
      for (int cv = 0; cv < 4; cv++) begin
        int ones_in;
        @(posedge clk);
        cx = 5'(xv); cci = 2'(cv);
        @(negedge clk);
        ones_in = $countones(cx) + $countones(cci);
        chk({fs, f1, f2, fy} == {rs, r1, r2, ry}, "R7", 64'({fs, f1, f2, fy}), 64'({rs, r1, r2, ry}));
        chk(int'(fs) + 2 * (int'(f1) + int'(f2) + int'(fy)) == ones_in, "R2",
            64'(int'(fs) + 2 * (int'(f1) + int'(f2) + int'(fy))), 64'(ones_in));
        chk(f1 == ($countones(cx[2:0]) >= 2), "R3", 64'(f1), 64'($countones(cx[2:0]) >= 2));
        if (cv == 0) begin
          base1 = f1; base2 = f2;
        end else begin
          chk(f1 == base1, "R3", 64'(f1), 64'(base1));
          chk(f2 == base2, "R4", 64'(f2), 64'(base2));
        end
      end
    end

    // directed row corners
    row_vec(ones, ones, ones, ones, ones);                    // R6 all-ones
    chk(TW'(sum_f) + (TW'(car_f) << 1) == TW'(5) * TW'(ones), "R6",
        64'(TW'(sum_f) + (TW'(car_f) << 1)), 64'(TW'(5) * TW'(ones)));
    row_vec(W'(1), W'(1), W'(1), W'(1), W'(1));               // R5 bit0 only
    row_vec(W'(1), W'(1), W'(0), W'(1), W'(0));
    row_vec({W/2{2'b10}}, {W/2{2'b01}}, {W/2{2'b10}}, {W/2{2'b01}}, ones);
    row_vec(ones, '0, ones, '0, ones);
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] m;
      m = W'(1) << k;
      row_vec(m, m, m, m, m);
    end

    // random
    for (int i = 0; i < 400; i++) begin
      row_vec(W'($urandom), W'($urandom), W'($urandom), W'($urandom), W'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule